// File: doc/BRIEF.md
# Program and Table Address Generator

This block produces the 16-bit word address for a 64K-word instruction and coefficient space. It keeps a program counter, a return pointer, an interrupt pointer, a table pointer and a signed offset. One 16-bit adder serves two purposes. On a fetch it adds 1 to the program counter. On a coefficient access it adds the offset to the table pointer after the pointer has been used. Subroutine call and return, and interrupt entry and exit, load the program counter from their own sources.

The block also decodes the address it outputs. It raises exactly one segment enable (ROM, RAM or external ROM), plus one enable for the 1K-word RAM bank being addressed. A map register picks which of four layouts the decode uses. A small data-bus port reads and writes the table, return and interrupt pointers and the offset. The program counter cannot be reached from that port.

The operation code works like a per-cycle command state. The states are HOLD, STEP, TABLE, CALL, RET, IRQ and IRET. Each state chooses the address source and the register transition for that cycle. Every state returns to the command given in the next cycle.

Top module: `ptab_addr_gen`

## Requirements
- R1: Synchronous active-high `rst` clears the program counter, the table, return and interrupt pointers, the offset and the map register to 0, so the first address out is 0x0000.
- R2: `op`=1 (STEP) outputs the program counter as the address, and the counter becomes counter+1 modulo 2^16. `op`=0 (HOLD) outputs the program counter and changes nothing.
- R3: `op`=2 (TABLE) outputs the table pointer as the address. The pointer then becomes pointer + offset, with the offset taken as two's complement and the sum wrapping at 16 bits. The program counter is unchanged.
- R4: `bus_rdata` always shows the register picked by `bus_sel`: 0 table pointer, 1 return pointer, 2 interrupt pointer, 3 offset. When `bus_we` is high, the next clock writes `bus_wdata` into that register.
- R5: A bus write to a register in the same cycle as a command that would update that register takes priority; the written value is kept.
- R6: `op`=3 (CALL) stores program counter+1 (mod 2^16) in the return pointer and loads the program counter from `tgt_addr`.
- R7: `op`=4 (RET) loads the program counter from the return pointer, and `op`=6 (IRET) loads it from the interrupt pointer.
- R8: `op`=5 (IRQ) copies the current program counter into the interrupt pointer and loads the program counter from `tgt_addr`.
- R9: `map_we` loads `map_wdata` into the map register at the next clock. The RAM region (NBANK KW, 4 KW by default) starts at 0x8000 in maps 0 and 2, at 0x0000 in map 1, and ends at 0xFFFF in map 3. Outside the RAM, the lower half 0x0000–0x7FFF is ROM in maps 0 and 3 and external ROM in maps 1 and 2; the upper half is external ROM in maps 0 and 3 and ROM in maps 1 and 2.
- R10: `seg_en` always has exactly one bit set: bit 0 ROM, bit 1 RAM, bit 2 external ROM.
- R11: `bank_en` is one-hot when the RAM is selected and zero otherwise. Bit k means the address lies in the k-th 1K-word block counted from the RAM base.
- R12: The unused code `op`=7 behaves as HOLD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Command for this cycle (0 HOLD, 1 STEP, 2 TABLE, 3 CALL, 4 RET, 5 IRQ, 6 IRET) |
| tgt_addr | input | 16 | Target for CALL and IRQ |
| bus_we | input | 1 | Data-bus write strobe |
| bus_sel | input | 2 | Data-bus register select |
| bus_wdata | input | 16 | Data-bus write value |
| bus_rdata | output | 16 | Data-bus read value of the selected register |
| map_we | input | 1 | Map register write strobe |
| map_wdata | input | 2 | New map number |
| xaddr | output | 16 | Memory address for this cycle |
| seg_en | output | 3 | One-hot segment enables (ROM, RAM, external ROM) |
| bank_en | output | NBANK | One-hot RAM bank enables |

## Verification
The hardest conditions to reach from the ports are the wrap points of the adder. These are the program counter stepping past 0xFFFF and the table pointer crossing 0x0000 or 0xFFFF under a negative or positive offset. The same applies to exact segment boundaries under each of the four maps. Random commands seldom land there. Directed sequences therefore use CALL with target 0xFFFF, then set the pointer and offset through the bus to the edge values. They also sweep the pointer over every boundary address of each map, using TABLE accesses with a zero offset. Same-cycle collisions between a bus write and a command update are forced on purpose and also occur in the random phase.

// File: rtl/ptab_pkg.sv
package ptab_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_STEP  = 3'd1,
        OP_TABLE = 3'd2,
        OP_CALL  = 3'd3,
        OP_RET   = 3'd4,
        OP_IRQ   = 3'd5,
        OP_IRET  = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        SEL_PT  = 2'd0,
        SEL_PR  = 2'd1,
        SEL_PI  = 2'd2,
        SEL_OFS = 2'd3
    } sel_e;

    localparam int SEG_ROM  = 0;
    localparam int SEG_RAM  = 1;
    localparam int SEG_EROM = 2;
    localparam int NSEG     = 3;
endpackage

// File: rtl/ptab_adder.sv
module ptab_adder #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] opa,
    input  logic [AW-1:0] opb,
    output logic [AW-1:0] sum
);
    assign sum = opa + opb;
endmodule

// File: rtl/ptab_seq.sv
module ptab_seq
    import ptab_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op,
    input  logic [AW-1:0] tgt_addr,
    input  logic          bus_we,
    input  logic [1:0]    bus_sel,
    input  logic [AW-1:0] bus_wdata,
    output logic [AW-1:0] bus_rdata,
    output logic [AW-1:0] xaddr
);
    logic [AW-1:0] pc_q, pt_q, pr_q, pi_q, ofs_q;
    logic [AW-1:0] add_a, add_b, add_s;
    op_e           cmd;
    sel_e          sel;

    assign cmd = op_e'(op);
    assign sel = sel_e'(bus_sel);

    ptab_adder #(.AW(AW)) u_add (.opa(add_a), .opb(add_b), .sum(add_s));

    always_comb begin
        add_a = pc_q;
        add_b = AW'(1);
        xaddr = pc_q;
        unique case (cmd)
            OP_TABLE: begin
                add_a = pt_q;
                add_b = ofs_q;
                xaddr = pt_q;
            end
            default: ;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_PT:  bus_rdata = pt_q;
            SEL_PR:  bus_rdata = pr_q;
            SEL_PI:  bus_rdata = pi_q;
            default: bus_rdata = ofs_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            pt_q  <= '0;
            pr_q  <= '0;
            pi_q  <= '0;
            ofs_q <= '0;
        end else begin
            unique case (cmd)
                OP_STEP:  pc_q <= add_s;
                OP_TABLE: pt_q <= add_s;
                OP_CALL: begin
                    pr_q <= add_s;
                    pc_q <= tgt_addr;
                end
                OP_RET:   pc_q <= pr_q;
                OP_IRQ: begin
                    pi_q <= pc_q;
                    pc_q <= tgt_addr;
                end
                OP_IRET:  pc_q <= pi_q;
                default:  ;
            endcase
            if (bus_we) begin
                unique case (sel)
                    SEL_PT:  pt_q  <= bus_wdata;
                    SEL_PR:  pr_q  <= bus_wdata;
                    SEL_PI:  pi_q  <= bus_wdata;
                    default: ofs_q <= bus_wdata;
                endcase
            end
        end
    end

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_STEP) |=> (pc_q == AW'($past(pc_q) + AW'(1))));

    p_pt_postmod_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_TABLE && !(bus_we && sel == SEL_PT))
        |=> (pt_q == AW'($past(pt_q) + $past(ofs_q))));

    p_pc_hold_table_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_TABLE) |=> $stable(pc_q));

    p_irq_save_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == OP_IRQ && !(bus_we && sel == SEL_PI)) |=> (pi_q == $past(pc_q)));
endmodule

// File: rtl/ptab_decode.sv
module ptab_decode
    import ptab_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NBANK  = 4,
    parameter int BANK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             map_we,
    input  logic [1:0]       map_wdata,
    input  logic [AW-1:0]    addr,
    output logic [NSEG-1:0]  seg_en,
    output logic [NBANK-1:0] bank_en
);
    localparam int          IDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1;
    localparam logic [AW:0] RAMSZ  = (AW+1)'(NBANK) << BANK_W;
    localparam logic [AW:0] HALF   = (AW+1)'(1) << (AW-1);
    localparam logic [AW:0] TOP    = (AW+1)'(1) << AW;

    logic [1:0]    map_q;
    logic [AW:0]   base, off;
    logic          in_ram, upper;
    logic [IDX_W-1:0] bidx;

    always_ff @(posedge clk) begin
        if (rst)         map_q <= '0;
        else if (map_we) map_q <= map_wdata;
    end

    always_comb begin
        unique case (map_q)
            2'd0:    base = HALF;
            2'd1:    base = '0;
            2'd2:    base = HALF;
            default: base = TOP - RAMSZ;
        endcase
        off    = {1'b0, addr} - base;
        in_ram = ({1'b0, addr} >= base) && (off < RAMSZ);
        upper  = addr[AW-1];
        bidx   = IDX_W'(off >> BANK_W);
        seg_en = '0;
        if (in_ram) begin
            seg_en[SEG_RAM] = 1'b1;
        end else begin
            unique case (map_q)
                2'd1, 2'd2: seg_en[upper ? SEG_ROM : SEG_EROM] = 1'b1;
                default:    seg_en[upper ? SEG_EROM : SEG_ROM] = 1'b1;
            endcase
        end
    end

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        assign bank_en[k] = in_ram && (bidx == IDX_W'(k));
    end

    p_seg_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_en) == 1);

    p_bank_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(bank_en) && ((bank_en != '0) == seg_en[SEG_RAM]));
endmodule

// File: rtl/ptab_addr_gen.sv
module ptab_addr_gen
    import ptab_pkg::*;
#(
    parameter int AW     = 16,
    parameter int NBANK  = 4,
    parameter int BANK_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op,
    input  logic [AW-1:0]    tgt_addr,
    input  logic             bus_we,
    input  logic [1:0]       bus_sel,
    input  logic [AW-1:0]    bus_wdata,
    output logic [AW-1:0]    bus_rdata,
    input  logic             map_we,
    input  logic [1:0]       map_wdata,
    output logic [AW-1:0]    xaddr,
    output logic [NSEG-1:0]  seg_en,
    output logic [NBANK-1:0] bank_en
);
    ptab_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .op(op), .tgt_addr(tgt_addr),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .xaddr(xaddr)
    );

    ptab_decode #(.AW(AW), .NBANK(NBANK), .BANK_W(BANK_W)) u_dec (
        .clk(clk), .rst(rst), .map_we(map_we), .map_wdata(map_wdata),
        .addr(xaddr), .seg_en(seg_en), .bank_en(bank_en)
    );
endmodule

// File: tb/sim_ptab_addr_gen.sv
module sim_ptab_addr_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op = '0;
    logic [15:0] tgt_addr = '0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = '0;
    logic [15:0] bus_wdata = '0;
    logic        map_we = 1'b0;
    logic [1:0]  map_wdata = '0;
    logic [15:0] bus_rdata, xaddr;
    logic [2:0]  seg_en;
    logic [3:0]  bank_en;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_pc, m_pt, m_pr, m_pi, m_ofs;
    logic [1:0]  m_map;

    always #4 clk = ~clk;

    ptab_addr_gen u0 (
        .clk(clk), .rst(rst), .op(op), .tgt_addr(tgt_addr),
        .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .map_we(map_we), .map_wdata(map_wdata),
        .xaddr(xaddr), .seg_en(seg_en), .bank_en(bank_en)
    );

    function automatic logic [16:0] ram_base(input logic [1:0] mp);
        case (mp)
            2'd0:    return 17'h08000;
            2'd1:    return 17'h00000;
            2'd2:    return 17'h08000;
            default: return 17'h10000 - 17'h01000;
        endcase
    endfunction

    function automatic logic [2:0] exp_seg(input logic [1:0] mp, input logic [15:0] a);
        logic [16:0] b;
        b = ram_base(mp);
        if ({1'b0, a} >= b && {1'b0, a} < b + 17'h01000) return 3'b010;
        if (mp == 2'd1 || mp == 2'd2) return a[15] ? 3'b001 : 3'b100;
        return a[15] ? 3'b100 : 3'b001;
    endfunction

    function automatic logic [3:0] exp_bank(input logic [1:0] mp, input logic [15:0] a);
        logic [16:0] d;
        if (exp_seg(mp, a) != 3'b010) return 4'b0000;
        d = {1'b0, a} - ram_base(mp);
        return 4'b0001 << d[11:10];
    endfunction

    function automatic logic [15:0] model_rd(input logic [1:0] s);
        case (s)
            2'd0:    return m_pt;
            2'd1:    return m_pr;
            2'd2:    return m_pi;
            default: return m_ofs;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] o, input logic [15:0] t, input logic bwe,
                       input logic [1:0] bs, input logic [15:0] bw,
                       input logic mwe, input logic [1:0] mw);
        logic [15:0] ea, n_pc, n_pt, n_pr, n_pi, n_ofs;
        string tg;
        op = o; tgt_addr = t; bus_we = bwe; bus_sel = bs; bus_wdata = bw;
        map_we = mwe; map_wdata = mw;
        #1;
        ea = (o == 3'd2) ? m_pt : m_pc;
        case (o)
            3'd2: tg = "R3";
            3'd7: tg = "R12";
            default: tg = "R2";
        endcase
        chk(xaddr == ea, tg, xaddr, ea);
        chk(seg_en == exp_seg(m_map, ea), "R9 R10", {13'b0, seg_en}, {13'b0, exp_seg(m_map, ea)});
        chk(bank_en == exp_bank(m_map, ea), "R11", {12'b0, bank_en}, {12'b0, exp_bank(m_map, ea)});
        chk(bus_rdata == model_rd(bs), "R4", bus_rdata, model_rd(bs));
        n_pc = m_pc; n_pt = m_pt; n_pr = m_pr; n_pi = m_pi; n_ofs = m_ofs;
        case (o)
            3'd1: n_pc = m_pc + 16'd1;
            3'd2: n_pt = m_pt + m_ofs;
            3'd3: begin n_pr = m_pc + 16'd1; n_pc = t; end
            3'd4: n_pc = m_pr;
            3'd5: begin n_pi = m_pc; n_pc = t; end
            3'd6: n_pc = m_pi;
            default: ;
        endcase
        if (bwe) begin
            case (bs)
                2'd0: n_pt = bw;
                2'd1: n_pr = bw;
                2'd2: n_pi = bw;
                default: n_ofs = bw;
            endcase
        end
        @(posedge clk);
        m_pc = n_pc; m_pt = n_pt; m_pr = n_pr; m_pi = n_pi; m_ofs = n_ofs;
        if (mwe) m_map = mw;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] v);
        cyc(3'd0, 16'h0, 1'b1, s, v, 1'b0, 2'd0);
    endtask

    task automatic rd_expect(input logic [1:0] s, input logic [15:0] v, input string tag);
        op = 3'd0; bus_we = 1'b0; map_we = 1'b0; bus_sel = s;
        #1;
        chk(bus_rdata == v, tag, bus_rdata, v);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] edges [13];
        void'($urandom(32'd4711));
        edges = '{16'h0000, 16'h7FFF, 16'h8000, 16'h83FF, 16'h8400, 16'h8FFF,
                  16'h9000, 16'hEFFF, 16'hF000, 16'hFFFF, 16'h0FFF, 16'h1000, 16'h0C00};
        m_pc = 0; m_pt = 0; m_pr = 0; m_pi = 0; m_ofs = 0; m_map = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        // R1: everything cleared
        #1;
        chk(xaddr == 16'h0000, "R1", xaddr, 16'h0000);
        for (int s = 0; s < 4; s++) rd_expect(2'(s), 16'h0000, "R1");
        chk(seg_en == 3'b001, "R1", {13'b0, seg_en}, 16'h0001);

        // R6 call to the last address, then R2 wrap
        cyc(3'd3, 16'hFFFF, 0, 2'd1, 0, 0, 0);
        rd_expect(2'd1, 16'h0001, "R6");
        cyc(3'd1, 0, 0, 2'd0, 0, 0, 0);
        cyc(3'd0, 0, 0, 2'd0, 0, 0, 0);
        chk(xaddr == 16'h0000, "R2", xaddr, 16'h0000);
        // R8 and R7
        cyc(3'd5, 16'h4321, 0, 2'd2, 0, 0, 0);
        rd_expect(2'd2, 16'h0000, "R8");
        cyc(3'd4, 0, 0, 2'd0, 0, 0, 0);
        chk(xaddr == 16'h0001, "R7", xaddr, 16'h0001);
        cyc(3'd6, 0, 0, 2'd0, 0, 0, 0);
        chk(xaddr == 16'h0000, "R7", xaddr, 16'h0000);
        // R3 wraps
        wr(2'd0, 16'hFFFF); wr(2'd3, 16'h0001);
        cyc(3'd2, 0, 0, 2'd0, 0, 0, 0);
        rd_expect(2'd0, 16'h0000, "R3");
        wr(2'd3, 16'hFFFF);
        cyc(3'd2, 0, 0, 2'd0, 0, 0, 0);
        rd_expect(2'd0, 16'hFFFF, "R3");
        // R5 collisions
        cyc(3'd2, 0, 1, 2'd0, 16'h1234, 0, 0);
        rd_expect(2'd0, 16'h1234, "R5");
        cyc(3'd5, 16'h0100, 1, 2'd2, 16'hBEEF, 0, 0);
        rd_expect(2'd2, 16'hBEEF, "R5");
        // R12: op 7 leaves PC alone
        cyc(3'd7, 16'h5555, 0, 2'd0, 0, 0, 0);
        cyc(3'd0, 0, 0, 2'd0, 0, 0, 0);
        chk(xaddr == 16'h0100, "R12", xaddr, 16'h0100);

        // R9 R10 R11 boundary sweep over all maps
        wr(2'd3, 16'h0000);
        for (int mp = 0; mp < 4; mp++) begin
            cyc(3'd0, 0, 0, 2'd0, 0, 1, 2'(mp));
            for (int e = 0; e < 13; e++) begin
                wr(2'd0, edges[e]);
                cyc(3'd2, 0, 0, 2'd0, 0, 0, 0);
            end
        end

        // random phase
        for (int n = 0; n < 5000; n++) begin
            logic [15:0] t;
            logic [15:0] w;
            t = ($urandom % 8 == 0) ? 16'hFFFF : 16'($urandom);
            w = ($urandom % 6 == 0) ? edges[$urandom % 13] : 16'($urandom);
            cyc(3'($urandom), t, ($urandom % 4 == 0), 2'($urandom), w,
                ($urandom % 16 == 0), 2'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule